// File: doc/BRIEF.md
# Bus-Master DMA Channel Register Block

This block holds the bus-master control state for a two-channel disk controller. Each channel has a command byte, a status byte, two spare storage bytes and a 32-bit descriptor-table pointer. Software reaches them through a byte-addressed register port with 1-, 2- or 4-byte accesses. The block turns command writes into start and abort pulses for a DMA engine and places each channel's descriptor pointer beside those pulses. It folds completion and fault events from the engine back into the status byte.

Start and stop are edge-triggered: a DMA request is issued only when a write changes the start/stop bit. The transfer direction is frozen while a transfer runs. The status byte combines a read-only active flag, two write-one-to-clear flags and several plain storage bits. Writes happen only when both the I/O enable and the bus-master enable from configuration are set.

Top module: `bmdma_chan_regs`

## Requirements
- R1: After reset, each channel's status byte reads 0x60 (drive-capable bits 5 and 6 set). The command byte, both spare bytes and the pointer read 0.
- R2: A command write that takes bit 0 (start/stop) from 0 to 1 sets status bit 0 (active). In the cycle after the write it pulses `dmaStart` for that channel, and the channel's pointer output holds the descriptor pointer.
- R3: A command write that takes bit 0 from 1 to 0 clears status bit 0. In the cycle after the write it pulses `dmaAbort` for that channel.
- R4: While command bit 0 is already 1, a command write leaves command bit 3 (direction) at its previous value.
- R5: Status bit 0 changes only through R2, R3 and R7. A status write never changes it.
- R6: Status bit 1 (error) and bit 2 (interrupt) clear only when they are 1 and a 1 is written to them. Writing 0 to them keeps them unchanged, and software cannot set them. A `dmaErr` pulse sets bit 1. Status bits 3 to 7 are plain storage.
- R7: A `dmaDone` pulse on a channel clears that channel's command bit 0 and status bit 0 and sets its status bit 2.
- R8: The pointer at channel offset +4 accepts only 4-byte writes and stores the data with bits 1:0 forced to 0.
- R9: An illegal write raises `accErr` for the one cycle after the write and changes no register. Illegal writes are: command (+0) or status (+2) with a size other than 1; the pointer with a size other than 4; any write at +5, +6 or +7; and any size other than 1, 2 or 4.
- R10: The spare bytes at channel offsets +1 and +3 accept writes of 1, 2 or 4 bytes. Data byte k goes to address offset+k. Bytes that land on a command, status or pointer location are dropped.
- R11: A write is ignored when `ioEn` or `bmEn` is low. No register changes and no `accErr` is raised.
- R12: Addresses 0 to 7 select the primary channel and 8 to 15 the secondary channel. `rData` returns the four bytes starting at `addr`, little-endian, with 0 for bytes past address 15.
- R13: While `ioEn` is low, `rData` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioEn | input | 1 | I/O decode enable from configuration |
| bmEn | input | 1 | Bus-master enable from configuration |
| wrEn | input | 1 | Write strobe for one cycle |
| addr | input | 4 | Byte address of the access |
| size | input | 3 | Access size in bytes (1, 2 or 4 legal) |
| wData | input | 32 | Write data, byte 0 in bits 7:0 |
| rData | output | 32 | Read data for `addr`, combinational |
| accErr | output | 1 | Illegal-size write response, one cycle after the write |
| dmaDone | input | 2 | Per-channel transfer-complete pulse |
| dmaErr | input | 2 | Per-channel transfer-fault pulse |
| dmaStart | output | 2 | Per-channel start request pulse |
| dmaAbort | output | 2 | Per-channel abort request pulse |
| dmaPtrPri | output | 32 | Primary channel descriptor pointer |
| dmaPtrSec | output | 32 | Secondary channel descriptor pointer |

## Verification
The assertions assume that `dmaDone` never arrives in the same cycle as a command write to the same channel. If it did, the completion would override a start request that was still being issued. They also assume that `dmaDone` and `dmaErr` are single-cycle pulses that are low during reset. The stimulus drives every completion and fault pulse in a cycle of its own, with no register write pending. It holds both event inputs at 0 during and around reset.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  localparam int NCHAN      = 2;
  localparam int CHAN_BYTES = 8;
  localparam int REG_BYTES  = NCHAN * CHAN_BYTES;
  localparam int ADDR_W     = $clog2(REG_BYTES);
  localparam int OFF_W      = $clog2(CHAN_BYTES);
  localparam int DATA_W     = 32;
  localparam int PTR_W      = 32;
  localparam int NSPARE     = NCHAN * 2;

  localparam int OFF_CMD    = 0;
  localparam int OFF_SPAREA = 1;
  localparam int OFF_STS    = 2;
  localparam int OFF_SPAREB = 3;
  localparam int OFF_PTR    = 4;

  localparam int CMD_SS  = 0;
  localparam int CMD_DIR = 3;
  localparam int STS_ACT = 0;
  localparam int STS_ERR = 1;
  localparam int STS_INT = 2;
  localparam logic [7:0] STS_RESET = 8'h60;

  typedef struct packed {
    logic [NCHAN-1:0]       cmdWr;
    logic [NCHAN-1:0]       stsWr;
    logic [NCHAN-1:0]       ptrWr;
    logic [NSPARE-1:0]      spareWr;
    logic [NSPARE-1:0][1:0] spareLane;
    logic                   err;
  } wrStrobe_t;
endpackage

// File: rtl/bmdma_ctrl.sv
module bmdma_ctrl
  import bmdma_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioEn,
  input  logic              bmEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        size,
  output wrStrobe_t         strb
);
  logic [OFF_W-1:0] off;
  logic             chan;
  logic             sizeOk;
  logic             legal;
  logic             go;

  assign off    = addr[OFF_W-1:0];
  assign chan   = addr[ADDR_W-1];
  assign sizeOk = (size == 3'd1) || (size == 3'd2) || (size == 3'd4);
  assign go     = wrEn && ioEn && bmEn;

  always_comb begin
    case (int'(off))
      OFF_CMD, OFF_STS:       legal = (size == 3'd1);
      OFF_SPAREA, OFF_SPAREB: legal = sizeOk;
      OFF_PTR:                legal = (size == 3'd4);
      default:                legal = 1'b0;
    endcase
  end

  always_comb begin
    strb     = '0;
    strb.err = go && !legal;
    if (go && legal) begin
      case (int'(off))
        OFF_CMD: strb.cmdWr[chan] = 1'b1;
        OFF_STS: strb.stsWr[chan] = 1'b1;
        OFF_PTR: strb.ptrWr[chan] = 1'b1;
        default: begin
          for (int s = 0; s < NSPARE; s++) begin
            int pos;
            pos = (s / 2) * CHAN_BYTES + (s % 2) * 2 + 1;
            if (pos >= int'(addr) && pos < int'(addr) + int'(size)) begin
              strb.spareWr[s]   = 1'b1;
              strb.spareLane[s] = 2'(pos - int'(addr));
            end
          end
        end
      endcase
    end
  end

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.err, |strb.cmdWr, |strb.stsWr, |strb.ptrWr, |strb.spareWr}));
endmodule

// File: rtl/bmdma_datapath.sv
module bmdma_datapath
  import bmdma_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        ioEn,
  input  wrStrobe_t                   strb,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [DATA_W-1:0]           wData,
  input  logic [NCHAN-1:0]            dmaDone,
  input  logic [NCHAN-1:0]            dmaErr,
  output logic [DATA_W-1:0]           rData,
  output logic                        accErr,
  output logic [NCHAN-1:0]            dmaStart,
  output logic [NCHAN-1:0]            dmaAbort,
  output logic [NCHAN-1:0][PTR_W-1:0] ptrOut
);
  logic [7:0]       cmdQ   [NCHAN];
  logic [7:0]       stsQ   [NCHAN];
  logic [PTR_W-1:0] ptrQ   [NCHAN];
  logic             startQ [NCHAN];
  logic             abortQ [NCHAN];
  logic [7:0]       spareQ [NSPARE];
  logic [7:0]       byteView [REG_BYTES];
  logic             errQ;

  always_ff @(posedge clk) begin
    if (!rstN) errQ <= 1'b0;
    else       errQ <= strb.err;
  end
  assign accErr = errQ;

  for (genvar c = 0; c < NCHAN; c++) begin : g_chan
    logic [7:0] cmdN, stsN;
    logic       startN, abortN;

    always_comb begin
      cmdN   = cmdQ[c];
      stsN   = stsQ[c];
      startN = 1'b0;
      abortN = 1'b0;
      if (strb.cmdWr[c]) begin
        cmdN = wData[7:0];
        if (cmdQ[c][CMD_SS]) cmdN[CMD_DIR] = cmdQ[c][CMD_DIR];
        if (!cmdQ[c][CMD_SS] && cmdN[CMD_SS]) begin
          startN        = 1'b1;
          stsN[STS_ACT] = 1'b1;
        end
        if (cmdQ[c][CMD_SS] && !cmdN[CMD_SS]) begin
          abortN        = 1'b1;
          stsN[STS_ACT] = 1'b0;
        end
      end
      if (strb.stsWr[c]) begin
        stsN = {wData[7:3],
                stsQ[c][STS_INT] & ~wData[STS_INT],
                stsQ[c][STS_ERR] & ~wData[STS_ERR],
                stsQ[c][STS_ACT]};
      end
      if (dmaErr[c]) stsN[STS_ERR] = 1'b1;
      if (dmaDone[c]) begin
        cmdN[CMD_SS]  = 1'b0;
        stsN[STS_ACT] = 1'b0;
        stsN[STS_INT] = 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cmdQ[c]   <= '0;
        stsQ[c]   <= STS_RESET;
        ptrQ[c]   <= '0;
        startQ[c] <= 1'b0;
        abortQ[c] <= 1'b0;
      end else begin
        cmdQ[c]   <= cmdN;
        stsQ[c]   <= stsN;
        startQ[c] <= startN;
        abortQ[c] <= abortN;
        if (strb.ptrWr[c]) ptrQ[c] <= {wData[PTR_W-1:2], 2'b00};
      end
    end

    assign dmaStart[c] = startQ[c];
    assign dmaAbort[c] = abortQ[c];
    assign ptrOut[c]   = ptrQ[c];

    always_comb begin
      byteView[c*CHAN_BYTES + OFF_CMD]    = cmdQ[c];
      byteView[c*CHAN_BYTES + OFF_SPAREA] = spareQ[2*c];
      byteView[c*CHAN_BYTES + OFF_STS]    = stsQ[c];
      byteView[c*CHAN_BYTES + OFF_SPAREB] = spareQ[2*c+1];
      for (int b = 0; b < 4; b++)
        byteView[c*CHAN_BYTES + OFF_PTR + b] = ptrQ[c][8*b +: 8];
    end

    // R2
    start_sets_active_chk: assert property (@(posedge clk) disable iff (!rstN)
      startQ[c] |-> stsQ[c][STS_ACT]);
    // R3
    abort_clears_active_chk: assert property (@(posedge clk) disable iff (!rstN)
      abortQ[c] |-> !stsQ[c][STS_ACT]);
    // R4
    dir_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
      (cmdQ[c][CMD_SS] && $past(cmdQ[c][CMD_SS])) |-> $stable(cmdQ[c][CMD_DIR]));
    // R5
    active_source_chk: assert property (@(posedge clk) disable iff (!rstN)
      !$stable(stsQ[c][STS_ACT]) |-> (startQ[c] || abortQ[c] || $past(dmaDone[c])));
    // R7
    done_effect_chk: assert property (@(posedge clk) disable iff (!rstN)
      $past(dmaDone[c]) |-> (!cmdQ[c][CMD_SS] && stsQ[c][STS_INT]));
    // R9
    err_keeps_ptr_chk: assert property (@(posedge clk) disable iff (!rstN)
      errQ |-> $stable(ptrQ[c]));
  end

  for (genvar s = 0; s < NSPARE; s++) begin : g_spare
    always_ff @(posedge clk) begin
      if (!rstN)                 spareQ[s] <= '0;
      else if (strb.spareWr[s])  spareQ[s] <= wData[8*strb.spareLane[s] +: 8];
    end
  end

  always_comb begin
    rData = '0;
    for (int i = 0; i < 4; i++) begin
      logic [ADDR_W:0] idx;
      idx = {1'b0, addr} + (ADDR_W+1)'(i);
      if (ioEn && int'(idx) < REG_BYTES) rData[8*i +: 8] = byteView[idx[ADDR_W-1:0]];
    end
  end
endmodule

// File: rtl/bmdma_chan_regs.sv
module bmdma_chan_regs
  import bmdma_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioEn,
  input  logic              bmEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        size,
  input  logic [DATA_W-1:0] wData,
  output logic [DATA_W-1:0] rData,
  output logic              accErr,
  input  logic [NCHAN-1:0]  dmaDone,
  input  logic [NCHAN-1:0]  dmaErr,
  output logic [NCHAN-1:0]  dmaStart,
  output logic [NCHAN-1:0]  dmaAbort,
  output logic [PTR_W-1:0]  dmaPtrPri,
  output logic [PTR_W-1:0]  dmaPtrSec
);
  wrStrobe_t                   strb;
  logic [NCHAN-1:0][PTR_W-1:0] ptrOut;

  bmdma_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .ioEn(ioEn), .bmEn(bmEn), .wrEn(wrEn),
    .addr(addr), .size(size), .strb(strb)
  );

  bmdma_datapath dp_i (
    .clk(clk), .rstN(rstN), .ioEn(ioEn), .strb(strb), .addr(addr),
    .wData(wData), .dmaDone(dmaDone), .dmaErr(dmaErr), .rData(rData),
    .accErr(accErr), .dmaStart(dmaStart), .dmaAbort(dmaAbort), .ptrOut(ptrOut)
  );

  assign dmaPtrPri = ptrOut[0];
  assign dmaPtrSec = ptrOut[1];
endmodule

// File: tb/bmdma_chan_regs_tb.sv
`timescale 1ns/1ps
module bmdma_chan_regs_tb_top;
  logic        clk = 1'b0;
  logic        rstN, ioEn, bmEn, wrEn;
  logic [3:0]  addr;
  logic [2:0]  size;
  logic [31:0] wData, rData, dmaPtrPri, dmaPtrSec;
  logic        accErr;
  logic [1:0]  dmaDone, dmaErr, dmaStart, dmaAbort;

  int  testCnt = 0;
  int  failCnt = 0;
  bit  finished = 1'b0;
  logic [1:0] lastStart, lastAbort;
  logic       lastErr;

  always #2 clk = ~clk;

  bmdma_chan_regs dut_i (
    .clk(clk), .rstN(rstN), .ioEn(ioEn), .bmEn(bmEn), .wrEn(wrEn),
    .addr(addr), .size(size), .wData(wData), .rData(rData), .accErr(accErr),
    .dmaDone(dmaDone), .dmaErr(dmaErr), .dmaStart(dmaStart), .dmaAbort(dmaAbort),
    .dmaPtrPri(dmaPtrPri), .dmaPtrSec(dmaPtrSec)
  );

  typedef struct packed {
    logic [3:0]  wAddr;
    logic [2:0]  wSize;
    logic [31:0] wVal;
    logic [3:0]  rAddr;
    logic [31:0] expVal;
    logic        expErr;
  } vec_t;

  localparam int NVEC = 15;
  localparam vec_t VECS [NVEC] = '{
    '{4'd4,  3'd4, 32'h1234_5677, 4'd4,  32'h1234_5674, 1'b0}, // R8
    '{4'd12, 3'd4, 32'hDEAD_BEEF, 4'd12, 32'hDEAD_BEEC, 1'b0}, // R8 R12
    '{4'd4,  3'd2, 32'h0000_FFFF, 4'd4,  32'h1234_5674, 1'b1}, // R9
    '{4'd0,  3'd2, 32'h0000_0008, 4'd0,  32'h0060_0000, 1'b1}, // R9
    '{4'd0,  3'd1, 32'h0000_0008, 4'd0,  32'h0060_0008, 1'b0}, // R12
    '{4'd1,  3'd1, 32'h0000_00A5, 4'd0,  32'h0060_A508, 1'b0}, // R10
    '{4'd3,  3'd4, 32'h4433_2211, 4'd0,  32'h1160_A508, 1'b0}, // R10
    '{4'd1,  3'd2, 32'h0000_BBCC, 4'd0,  32'h1160_CC08, 1'b0}, // R10
    '{4'd2,  3'd1, 32'h0000_00FF, 4'd0,  32'h11F8_CC08, 1'b0}, // R5 R6
    '{4'd2,  3'd1, 32'h0000_0067, 4'd0,  32'h1160_CC08, 1'b0}, // R6
    '{4'd10, 3'd1, 32'h0000_005A, 4'd8,  32'h0058_0000, 1'b0}, // R6 R12
    '{4'd5,  3'd1, 32'h0000_0077, 4'd4,  32'h1234_5674, 1'b1}, // R9
    '{4'd0,  3'd3, 32'h0000_0001, 4'd0,  32'h1160_CC08, 1'b1}, // R9
    '{4'd9,  3'd4, 32'h4433_2211, 4'd8,  32'h3358_1100, 1'b0}, // R10
    '{4'd15, 3'd2, 32'h0000_FFFF, 4'd12, 32'hDEAD_BEEC, 1'b1}  // R9
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; wrEn = 1'b0; dmaDone = '0; dmaErr = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic doWrite(logic [3:0] a, logic [2:0] s, logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; size = s; wData = d;
    @(negedge clk);
    wrEn = 1'b0;
    lastStart = dmaStart; lastAbort = dmaAbort; lastErr = accErr;
  endtask

  task automatic readAt(logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rData;
  endtask

  task automatic pulseEvent(logic [1:0] done, logic [1:0] fault);
    @(negedge clk);
    dmaDone = done; dmaErr = fault;
    @(negedge clk);
    dmaDone = '0; dmaErr = '0;
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      failCnt++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rstN = 1'b0; ioEn = 1'b1; bmEn = 1'b1; wrEn = 1'b0;
    addr = '0; size = 3'd1; wData = '0; dmaDone = '0; dmaErr = '0;
    doReset();

    // R1 reset state
    readAt(4'd0, v);  check("R1 pri cmd/sts", v, 32'h0060_0000);
    readAt(4'd4, v);  check("R1 pri ptr", v, 32'h0);
    readAt(4'd8, v);  check("R1 sec cmd/sts", v, 32'h0060_0000);
    readAt(4'd12, v); check("R1 sec ptr", v, 32'h0);
    check("R1 accErr", {31'd0, accErr}, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      doWrite(VECS[i].wAddr, VECS[i].wSize, VECS[i].wVal);
      check($sformatf("R9 vec%0d err", i), {31'd0, lastErr}, {31'd0, VECS[i].expErr});
      readAt(VECS[i].rAddr, v);
      check($sformatf("R10/R12 vec%0d data", i), v, VECS[i].expVal);
    end

    doReset();
    // R2 start edge
    doWrite(4'd4, 3'd4, 32'h0000_0100);
    doWrite(4'd0, 3'd1, 32'h0000_0009);
    check("R2 start pulse", {30'd0, lastStart}, 32'h1);
    check("R2 ptr out", dmaPtrPri, 32'h0000_0100);
    readAt(4'd0, v); check("R2 active set", v, 32'h0061_0009);
    // R4 direction locked
    doWrite(4'd0, 3'd1, 32'h0000_0001);
    check("R4 no second start", {30'd0, lastStart}, 32'h0);
    readAt(4'd0, v); check("R4 dir kept", v, 32'h0061_0009);
    // R5 active read-only
    doWrite(4'd2, 3'd1, 32'h0000_0060);
    readAt(4'd0, v); check("R5 active kept", v, 32'h0061_0009);
    // R3 stop edge
    doWrite(4'd0, 3'd1, 32'h0000_0008);
    check("R3 abort pulse", {30'd0, lastAbort}, 32'h1);
    readAt(4'd0, v); check("R3 active cleared", v, 32'h0060_0008);
    // R7 completion
    doWrite(4'd0, 3'd1, 32'h0000_0001);
    check("R2 restart pulse", {30'd0, lastStart}, 32'h1);
    pulseEvent(2'b01, 2'b00);
    readAt(4'd0, v); check("R7 done effect", v, 32'h0064_0000);
    // R6 write-one-to-clear
    doWrite(4'd2, 3'd1, 32'h0000_0060);
    readAt(4'd0, v); check("R6 int kept on 0", v, 32'h0064_0000);
    doWrite(4'd2, 3'd1, 32'h0000_0064);
    readAt(4'd0, v); check("R6 int cleared", v, 32'h0060_0000);
    pulseEvent(2'b00, 2'b01);
    readAt(4'd0, v); check("R6 err set by fault", v, 32'h0062_0000);
    doWrite(4'd2, 3'd1, 32'h0000_0060);
    readAt(4'd0, v); check("R6 err kept on 0", v, 32'h0062_0000);
    doWrite(4'd2, 3'd1, 32'h0000_0062);
    readAt(4'd0, v); check("R6 err cleared", v, 32'h0060_0000);
    // R11 enables gate writes
    bmEn = 1'b0;
    doWrite(4'd0, 3'd1, 32'h0000_0001);
    check("R11 no start bm off", {30'd0, lastStart}, 32'h0);
    doWrite(4'd0, 3'd3, 32'h0000_0001);
    check("R11 no err bm off", {31'd0, lastErr}, 32'h0);
    bmEn = 1'b1;
    readAt(4'd0, v); check("R11 cmd unchanged", v, 32'h0060_0000);
    ioEn = 1'b0;
    doWrite(4'd4, 3'd4, 32'hFFFF_FFFF);
    // R13 reads zero with io off
    readAt(4'd0, v); check("R13 read zero", v, 32'h0);
    ioEn = 1'b1;
    readAt(4'd4, v); check("R11 ptr unchanged", v, 32'h0000_0100);
    // R12 secondary channel
    doWrite(4'd12, 3'd4, 32'h0000_2000);
    doWrite(4'd8, 3'd1, 32'h0000_0001);
    check("R12 sec start", {30'd0, lastStart}, 32'h2);
    check("R12 sec ptr out", dmaPtrSec, 32'h0000_2000);
    readAt(4'd0, v); check("R12 pri untouched", v, 32'h0060_0000);
    pulseEvent(2'b10, 2'b00);
    readAt(4'd8, v); check("R7 sec done", v, 32'h0064_0000);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule